// File: doc/BRIEF.md
# Two-Dimensional Strided Word-Address Sequencer

This block produces the word addresses of one DMA channel. It walks a two-dimensional pattern: a number of lines, each a run of consecutive 32-bit words, with a fixed distance between the starts of neighbouring lines. Before a transfer, software places a word-aligned start address, a line length, a line stride and a line count on the configuration inputs. A start pulse then launches the sequencer. From the next cycle it presents one address per beat with `valid_o`. The data path consumes an address by raising `ready_i`, and only a consumed address lets the sequencer move on.

A line length of zero selects circular mode. The block then treats a region of stride × (count+1) words as a ring. It steps through the ring one word at a time and jumps back to the start address after the last word. It signals an event when it leaves each half of the ring. Circular mode keeps going until the loop-enable input is low as the last word of the ring is consumed. A stop input aborts either mode at once.

All addresses, lengths and strides count 32-bit words. The data movement itself happens outside this block.

Top module: `strided_addr_seq`

## Requirements
- R1: After reset `valid_o`, `done_o` and `ring_evt_o` are low.
- R2: A `start_i` pulse while idle latches the configuration, and `valid_o` is high with `addr_o` equal to `base_i` in the next cycle. A `start_i` pulse or changed configuration inputs while `valid_o` is high have no effect on the address sequence.
- R3: The address advances only on a cycle where `valid_o` and `ready_i` are both high. While `ready_i` is low, `addr_o` and `valid_o` hold.
- R4: In line mode (`xlen_i` nonzero), a line consists of `xlen_i` consecutive addresses. Each line starts `stride_i` words after the start of the previous line, so word x of line y is at base + y·stride + x.
- R5: Line mode produces `ylen_i`+1 lines. A count of 0 gives exactly one line.
- R6: In the cycle after the last word of the last line is consumed, `valid_o` is low and `done_o` is high for exactly one cycle.
- R7: With `xlen_i` = 0 the block runs in circular mode. The address at beat k is base + (k mod T), where T = `stride_i`·(`ylen_i`+1).
- R8: In circular mode, `ring_evt_o` pulses for one cycle after the word at ring offset floor(T/2)−1 is consumed, with `ring_seg_o` = 0. It also pulses after the word at offset T−1 is consumed, with `ring_seg_o` = 1. When T = 1 only the second event occurs. No other cycle has `ring_evt_o` high.
- R9: Circular mode keeps running whatever `loop_en_i` is, except at one point. When the word at offset T−1 is consumed while `loop_en_i` is low, the channel goes idle and pulses `done_o` in the next cycle.
- R10: `stop_i` makes the block idle in the next cycle, with no `done_o` and no `ring_evt_o` there. This also holds when stop coincides with a final or event-causing beat. `stop_i` wins over `start_i` while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch a transfer when idle |
| stop_i | input | 1 | Abort and return to idle |
| loop_en_i | input | 1 | Keep circular mode running past the end of the ring |
| ready_i | input | 1 | Data path consumes the presented address |
| base_i | input | AW | Start word address (byte address shifted right by two) |
| xlen_i | input | LW | Words per line; zero selects circular mode |
| stride_i | input | LW | Words from one line start to the next |
| ylen_i | input | LW | Number of lines minus one |
| valid_o | output | 1 | An address is presented |
| addr_o | output | AW | Current word address |
| done_o | output | 1 | One-cycle pulse after a transfer finishes normally |
| ring_evt_o | output | 1 | One-cycle pulse at a half-ring boundary |
| ring_seg_o | output | 1 | Which boundary: 0 first half, 1 second half |

## Verification
The line walk is tried with several configurations:
- Contiguous lines, where stride equals length, cannot be told apart from a flat count; this case shows that the line structure does not break up a dense walk.
- Gapped lines, where stride exceeds length, and overlapping lines, where stride is below length, show that each line start comes from the stride and not from where the previous line ended.
- A single word and single-line transfers test the count-minus-one encoding.
- Irregular ready stalls separate beat counting from cycle counting.

Circular runs test the half-point rounding:
- An even ring of 8 words.
- An odd ring of 9 words, which separates floor from ceiling at the half point.
- A ring of 1 word, whose half point is empty.

Stops are placed on a final beat and on a half-point beat to show that pending pulses are dropped.

// File: rtl/sadg_pkg.sv
package sadg_pkg;
  typedef enum logic {
    SEQ_LINES = 1'b0,
    SEQ_RING  = 1'b1
  } seq_mode_e;
endpackage

// File: rtl/sadg_walk2d.sv
module sadg_walk2d #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          load,
  input  logic          adv,
  input  logic [AW-1:0] base_i,
  input  logic [LW-1:0] xlen_i,
  input  logic [LW-1:0] stride_i,
  input  logic [LW-1:0] ylen_i,
  input  logic [AW-1:0] cur_addr,
  output logic [AW-1:0] next_addr,
  output logic          last
);
  logic [LW-1:0] xl_q, st_q, yl_q, col_q, row_q;
  logic [AW-1:0] lbase_q;
  logic          line_end;

  assign line_end  = (col_q == xl_q - LW'(1));
  assign last      = line_end && (row_q == yl_q);
  assign next_addr = line_end ? (lbase_q + AW'(st_q)) : (cur_addr + AW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      xl_q <= '0; st_q <= '0; yl_q <= '0;
      col_q <= '0; row_q <= '0; lbase_q <= '0;
    end else if (load) begin
      xl_q <= xlen_i; st_q <= stride_i; yl_q <= ylen_i;
      col_q <= '0; row_q <= '0; lbase_q <= base_i;
    end else if (adv) begin
      if (line_end) begin
        col_q   <= '0;
        row_q   <= row_q + LW'(1);
        lbase_q <= lbase_q + AW'(st_q);
      end else begin
        col_q <= col_q + LW'(1);
      end
    end
  end

  // R4: column stays inside the line while a line walk is running
  a_r4_col_in_line: assert property (@(posedge clk) disable iff (rst)
    (active && adv) |-> (col_q < xl_q));
  // R5: row never passes the programmed count
  a_r5_row_bound: assert property (@(posedge clk) disable iff (rst)
    (active && adv) |-> (row_q <= yl_q));
endmodule

// File: rtl/sadg_ring.sv
module sadg_ring #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          load,
  input  logic          adv,
  input  logic [LW-1:0] stride_i,
  input  logic [LW-1:0] ylen_i,
  output logic          hit_half,
  output logic          hit_end
);
  localparam int CW = 2 * LW;

  logic [CW-1:0] total_q, half_q, off_q;

  assign hit_half = (half_q != '0) && (off_q == half_q - CW'(1));
  assign hit_end  = (off_q == total_q - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      total_q <= '0; half_q <= '0; off_q <= '0;
    end else if (load) begin
      total_q <= CW'(stride_i) * (CW'(ylen_i) + CW'(1));
      half_q  <= (CW'(stride_i) * (CW'(ylen_i) + CW'(1))) >> 1;
      off_q   <= '0;
    end else if (adv) begin
      off_q <= hit_end ? '0 : off_q + CW'(1);
    end
  end

  // R7: ring offset stays inside the region
  a_r7_off_in_region: assert property (@(posedge clk) disable iff (rst)
    (active && total_q != '0) |-> (off_q < total_q));
  // R8: half point precedes the end of the ring
  a_r8_half_before_end: assert property (@(posedge clk) disable iff (rst)
    hit_half |-> !hit_end);
endmodule

// File: rtl/strided_addr_seq.sv
module strided_addr_seq
  import sadg_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          loop_en_i,
  input  logic          ready_i,
  input  logic [AW-1:0] base_i,
  input  logic [LW-1:0] xlen_i,
  input  logic [LW-1:0] stride_i,
  input  logic [LW-1:0] ylen_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic          done_o,
  output logic          ring_evt_o,
  output logic          ring_seg_o
);
  logic          run_q;
  seq_mode_e     mode_q;
  logic [AW-1:0] base_q;
  logic          load, acc;
  logic [AW-1:0] w_next;
  logic          w_last, r_half, r_end;

  assign valid_o = run_q;
  assign load    = start_i && !run_q && !stop_i;
  assign acc     = run_q && ready_i && !stop_i;

  sadg_walk2d #(.AW(AW), .LW(LW)) u_walk (
    .clk(clk), .rst(rst),
    .active(run_q && mode_q == SEQ_LINES),
    .load(load), .adv(acc && mode_q == SEQ_LINES),
    .base_i(base_i), .xlen_i(xlen_i), .stride_i(stride_i), .ylen_i(ylen_i),
    .cur_addr(addr_o), .next_addr(w_next), .last(w_last)
  );

  sadg_ring #(.LW(LW)) u_ring (
    .clk(clk), .rst(rst),
    .active(run_q && mode_q == SEQ_RING),
    .load(load), .adv(acc && mode_q == SEQ_RING),
    .stride_i(stride_i), .ylen_i(ylen_i),
    .hit_half(r_half), .hit_end(r_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q      <= 1'b0;
      mode_q     <= SEQ_LINES;
      base_q     <= '0;
      addr_o     <= '0;
      done_o     <= 1'b0;
      ring_evt_o <= 1'b0;
      ring_seg_o <= 1'b0;
    end else begin
      done_o     <= 1'b0;
      ring_evt_o <= 1'b0;
      if (stop_i) begin
        run_q <= 1'b0;
      end else if (load) begin
        run_q  <= 1'b1;
        mode_q <= (xlen_i == '0) ? SEQ_RING : SEQ_LINES;
        base_q <= base_i;
        addr_o <= base_i;
      end else if (acc) begin
        if (mode_q == SEQ_LINES) begin
          if (w_last) begin
            run_q  <= 1'b0;
            done_o <= 1'b1;
          end else begin
            addr_o <= w_next;
          end
        end else begin
          if (r_half) begin
            ring_evt_o <= 1'b1;
            ring_seg_o <= 1'b0;
          end
          if (r_end) begin
            ring_evt_o <= 1'b1;
            ring_seg_o <= 1'b1;
            addr_o     <= base_q;
            if (!loop_en_i) begin
              run_q  <= 1'b0;
              done_o <= 1'b1;
            end
          end else begin
            addr_o <= addr_o + AW'(1);
          end
        end
      end
    end
  end

  // R3: a stalled beat keeps its address
  a_r3_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !ready_i && !stop_i) |=> (valid_o && $stable(addr_o)));
  // R6: done is a lone pulse seen only when idle
  a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !valid_o);
  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R8: ring events only come from circular mode
  a_r8_evt_ring_only: assert property (@(posedge clk) disable iff (rst)
    ring_evt_o |-> (mode_q == SEQ_RING));
  // R10: stop leaves the channel idle and silent
  a_r10_stop_quiet: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> (!valid_o && !done_o && !ring_evt_o));
endmodule

// File: tb/tb_strided_addr_seq.sv
module tb_strided_addr_seq;
  localparam int AW = 32;
  localparam int LW = 16;
  localparam int NV = 6;
  // line-mode vectors: base, xlen, stride, ylen, stall
  localparam int VB [NV] = '{100, 200, 50, 1000, 30, 10};
  localparam int VX [NV] = '{4,   3,   1,  5,    2,  4};
  localparam int VS [NV] = '{4,   8,   1,  16,   10, 2};
  localparam int VY [NV] = '{2,   3,   0,  0,    4,  1};
  localparam int VT [NV] = '{0,   1,   0,  1,    1,  0};

  logic clk = 1'b0, rst = 1'b1;
  logic start_i = 0, stop_i = 0, loop_en_i = 0, ready_i = 0;
  logic [AW-1:0] base_i = '0;
  logic [LW-1:0] xlen_i = '0, stride_i = '0, ylen_i = '0;
  logic valid_o, done_o, ring_evt_o, ring_seg_o;
  logic [AW-1:0] addr_o;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  strided_addr_seq #(.AW(AW), .LW(LW)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
    .loop_en_i(loop_en_i), .ready_i(ready_i), .base_i(base_i),
    .xlen_i(xlen_i), .stride_i(stride_i), .ylen_i(ylen_i),
    .valid_o(valid_o), .addr_o(addr_o), .done_o(done_o),
    .ring_evt_o(ring_evt_o), .ring_seg_o(ring_seg_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic launch(input int b, input int x, input int s, input int y);
    @(negedge clk);
    base_i = AW'(b); xlen_i = LW'(x); stride_i = LW'(s); ylen_i = LW'(y);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // junk configuration while busy must not matter (R2)
    base_i = AW'(9999); xlen_i = LW'(7); stride_i = LW'(33); ylen_i = LW'(5);
    chk(valid_o == 1'b1, "R2 valid after start", valid_o, 1);
    chk(addr_o == AW'(b), "R2 first address", addr_o, b);
  endtask

  task automatic run_lines(input int b, input int x, input int s, input int y, input int stall);
    int n, idx, cyc;
    bit rdy;
    n = x * (y + 1);
    idx = 0; cyc = 0;
    launch(b, x, s, y);
    while (idx < n) begin
      rdy = (stall != 0) ? ((cyc % 3) != 1) : 1'b1;
      ready_i = rdy;
      start_i = (cyc == 1);
      chk(valid_o == 1'b1 && done_o == 1'b0, "R5 still running", valid_o, 1);
      if (rdy) begin
        // R4: word x of line y at base + y*stride + x; R3 stalls hold
        chk(addr_o == AW'(b + (idx / x) * s + (idx % x)), "R4 line address",
            addr_o, b + (idx / x) * s + (idx % x));
        idx++;
      end
      @(negedge clk);
      cyc++;
    end
    ready_i = 1'b0; start_i = 1'b0;
    chk(done_o == 1'b1, "R6 done pulse", done_o, 1);
    chk(valid_o == 1'b0, "R6 idle after last", valid_o, 0);
    @(negedge clk);
    chk(done_o == 1'b0, "R6 done one cycle", done_o, 0);
  endtask

  task automatic run_ring(input int b, input int s, input int y, input int nloops, input int stall);
    int tot, half, beats, idx, cyc, k;
    bit rdy, pe, ps;
    tot = s * (y + 1); half = tot / 2; beats = nloops * tot;
    idx = 0; cyc = 0; pe = 0; ps = 0;
    loop_en_i = 1'b1;
    launch(b, 0, s, y);
    while (idx < beats) begin
      chk(ring_evt_o == pe, "R8 ring event timing", ring_evt_o, pe);
      if (pe) chk(ring_seg_o == ps, "R8 ring event half", ring_seg_o, ps);
      chk(valid_o == 1'b1 && done_o == 1'b0, "R9 ring keeps running", valid_o, 1);
      rdy = (stall != 0) ? ((cyc % 3) != 1) : 1'b1;
      ready_i = rdy;
      start_i = (cyc == 1);
      loop_en_i = !((idx == beats - 1) || (tot > 1 && idx > 0 && (idx % tot) == 0));
      if (rdy) begin
        k = idx % tot;
        chk(addr_o == AW'(b + k), "R7 ring address", addr_o, b + k);
        pe = (half > 0 && k == half - 1) || (k == tot - 1);
        ps = (k == tot - 1);
        idx++;
      end else begin
        pe = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    ready_i = 1'b0; start_i = 1'b0; loop_en_i = 1'b0;
    chk(ring_evt_o == 1'b1 && ring_seg_o == 1'b1, "R8 end-of-ring event", ring_evt_o, 1);
    chk(done_o == 1'b1 && valid_o == 1'b0, "R9 ring ends on loop enable low", done_o, 1);
    @(negedge clk);
    chk(ring_evt_o == 1'b0 && done_o == 1'b0, "R8 pulses one cycle", ring_evt_o, 0);
  endtask

  initial begin
    int wd;
    wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", wd, 100000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(valid_o == 1'b0, "R1 valid reset", valid_o, 0);
    chk(done_o == 1'b0, "R1 done reset", done_o, 0);
    chk(ring_evt_o == 1'b0, "R1 event reset", ring_evt_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(valid_o == 1'b0, "R1 idle after reset", valid_o, 0);

    for (int v = 0; v < NV; v++) run_lines(VB[v], VX[v], VS[v], VY[v], VT[v]);

    run_ring(400, 1, 7, 2, 0);   // even ring, T=8
    run_ring(500, 3, 2, 2, 1);   // odd ring, T=9, half rounds down to 4
    run_ring(600, 1, 0, 3, 0);   // T=1, only end events

    // R10: stop mid line walk
    launch(300, 4, 4, 3);
    ready_i = 1'b1; @(negedge clk); @(negedge clk);
    stop_i = 1'b1; @(negedge clk);
    stop_i = 1'b0; ready_i = 1'b0;
    chk(valid_o == 1'b0 && done_o == 1'b0, "R10 stop mid walk", valid_o, 0);

    // R10: stop on the final beat drops done
    launch(310, 2, 2, 0);
    ready_i = 1'b1; @(negedge clk);
    stop_i = 1'b1; @(negedge clk);
    stop_i = 1'b0; ready_i = 1'b0;
    chk(done_o == 1'b0, "R10 stop drops done", done_o, 0);
    chk(valid_o == 1'b0, "R10 idle after stop", valid_o, 0);

    // R10: stop on ring half point drops event
    loop_en_i = 1'b1;
    launch(320, 0, 1, 3);
    ready_i = 1'b1; @(negedge clk);
    stop_i = 1'b1; @(negedge clk);
    stop_i = 1'b0; ready_i = 1'b0;
    chk(ring_evt_o == 1'b0, "R10 stop drops ring event", ring_evt_o, 0);
    chk(valid_o == 1'b0, "R10 ring idle after stop", valid_o, 0);

    // R10: stop wins over start while idle
    @(negedge clk);
    base_i = AW'(77); xlen_i = LW'(2); stride_i = LW'(2); ylen_i = '0;
    start_i = 1'b1; stop_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; stop_i = 1'b0;
    chk(valid_o == 1'b0, "R10 stop beats start", valid_o, 0);

    // R3: long stall holds address, then R2 fresh start after stop
    launch(800, 3, 3, 0);
    repeat (5) @(negedge clk);
    chk(valid_o == 1'b1 && addr_o == AW'(800), "R3 stall holds", addr_o, 800);
    ready_i = 1'b1; @(negedge clk); ready_i = 1'b0;
    chk(addr_o == AW'(801), "R3 single advance", addr_o, 801);
    @(negedge clk);
    chk(addr_o == AW'(801), "R3 hold after advance", addr_o, 801);
    stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule